// File: doc/BRIEF.md
# Glitch-Free Four-Channel Reference Clock Fan-Out

This block takes one reference clock and drives four output channels from it. Each channel has a true output and a complement output. A channel runs only while two things are both high: its own hardware enable pin and its control bit in a small byte-wide register bank. The register bank is written and read through a simple synchronous port in the reference clock domain. The port has an address, a write strobe and a combinational read path.

Enables may change at any time, with no relation to the reference clock. Each channel's effective enable is first synchronized on falling edges of the reference clock. The true output is then gated while the clock is low, and the complement output is gated while the clock is high. A channel that is disabled finishes its current pulses at full width and then rests with both outputs low. A channel that is re-enabled restarts with full-width pulses.

Top module: `ref_clk_fanout`

## Requirements
- R1: The four channels are independent: changing one channel's enable sources never alters the outputs of the other three.
- R2: The effective enable of channel c is hw_en_i[c] AND its control bit. If either is low, the channel stops.
- R3: Control bit positions: channel 0 = byte 1 bit 2, channel 1 = byte 1 bit 0, channel 2 = byte 2 bit 7, channel 3 = byte 2 bit 6.
- R4: Suppose a channel's effective enable is low when sampled at two consecutive falling edges of ref_clk_i. Then both clk_p_o and clk_n_o of that channel are low from the next rising edge onward, for as long as the enable stays low.
- R5: Suppose the effective enable is high when sampled at two consecutive falling edges. Then after the next rising edge, clk_p_o equals ref_clk_i and clk_n_o equals its inverse.
- R6: While rst_ni is low, all outputs are low. After reset, bytes 1 and 2 read 0x05 and 0xC0 (all four control bits set), and bytes 0 and 3 read 0x00.
- R7: No output pulse, high or low, is shorter than half a reference period, whatever the time at which an enable changes.
- R8: When wr_en_i is high at a rising edge, byte wr_addr_i takes wr_data_i, and rd_data_o shows byte rd_addr_i combinationally. Bits not listed in R3 read back as written and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Reference clock, also clocks the register port |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_en_i | input | 4 | Per-channel hardware enable pins, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register byte address for writes |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | ADDR_W | Register byte address for reads |
| rd_data_o | output | 8 | Read data of byte rd_addr_i |
| clk_p_o | output | 4 | True clock output per channel |
| clk_n_o | output | 4 | Complement clock output per channel |

## Verification
A behavioural model predicts the expected level of every output from the enable history it has sampled on falling edges. The bench first tries steady patterns: all channels on, then each channel switched off in turn through its register bit only, which tells apart the four bit positions and catches a swapped mapping. It then tries mixed patterns of pin and register enables, which separate an AND from an OR or a single-source enable. A sweep toggles one channel's pin at offsets spread across the whole reference period while a pulse-width monitor watches all eight outputs; this exposes runt pulses, zero-width glitches and crosstalk into the other channels. Writes of arbitrary values to unmapped bits are then read back, while the model confirms that the outputs stay unchanged.

// File: rtl/clk_fan_pkg.sv
`timescale 1ns/1ps
package clk_fan_pkg;
  localparam int unsigned NUM_CH = 4;

  typedef logic [7:0] byte_t;

  // register byte holding each channel's control bit
  function automatic int ch_byte(input int ch);
    return (ch < 2) ? 1 : 2;
  endfunction

  // bit position inside that byte
  function automatic int ch_bit(input int ch);
    case (ch)
      0:       return 2;
      1:       return 0;
      2:       return 7;
      default: return 6;
    endcase
  endfunction

  function automatic byte_t reset_byte(input int b);
    byte_t v;
    v = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (ch_byte(c) == b) v[ch_bit(c)] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/fan_ctrl_regs.sv
`timescale 1ns/1ps
module fan_ctrl_regs
  import clk_fan_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  parameter int unsigned AW     = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  byte_t         wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output byte_t         rd_data_o,
  output byte_t         regs_o [NBYTES]
);
  byte_t regs_q [NBYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NBYTES; b++) regs_q[b] <= reset_byte(b);
    end else if (wr_en_i) begin
      for (int b = 0; b < NBYTES; b++)
        if (wr_addr_i == b[AW-1:0]) regs_q[b] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NBYTES; b++)
      if (rd_addr_i == b[AW-1:0]) rd_data_o = regs_q[b];
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/fan_en_sync.sv
`timescale 1ns/1ps
module fan_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  // falling-edge capture: output only moves while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/fan_gate_cell.sv
`timescale 1ns/1ps
module fan_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_p_o,
  output logic clk_n_o
);
  logic en_n_q;

  // complement gate moves on the rising edge, while its phase is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_n_q <= 1'b0;
    else         en_n_q <= en_i;
  end

  assign clk_p_o = clk_i & en_i;
  assign clk_n_o = ~clk_i & en_n_q;
endmodule

// File: rtl/ref_clk_fanout.sv
`timescale 1ns/1ps
module ref_clk_fanout
  import clk_fan_pkg::*;
#(
  parameter  int unsigned NUM_BYTES   = 4,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W      = $clog2(NUM_BYTES)
) (
  input  logic              ref_clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hw_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [NUM_CH-1:0] clk_p_o,
  output logic [NUM_CH-1:0] clk_n_o
);
  byte_t             regs [NUM_BYTES];
  logic [NUM_CH-1:0] reg_en;
  logic [NUM_CH-1:0] eff_en;
  logic [NUM_CH-1:0] sync_en;

  fan_ctrl_regs #(
    .NBYTES (NUM_BYTES),
    .AW     (ADDR_W)
  ) u_regs (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .regs_o    (regs)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BY = ch_byte(c);
    localparam int BI = ch_bit(c);

    assign reg_en[c] = regs[BY][BI];
    assign eff_en[c] = hw_en_i[c] & reg_en[c];

    fan_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (ref_clk_i),
      .rst_ni (rst_ni),
      .d_i    (eff_en[c]),
      .q_o    (sync_en[c])
    );

    fan_gate_cell u_gate (
      .clk_i   (ref_clk_i),
      .rst_ni  (rst_ni),
      .en_i    (sync_en[c]),
      .clk_p_o (clk_p_o[c]),
      .clk_n_o (clk_n_o[c])
    );
  end
endmodule

// File: rtl/ref_clk_fanout_chk.sv
`timescale 1ns/1ps
module ref_clk_fanout_chk #(
  parameter int unsigned AW = 2
) (
  input logic          ref_clk_i,
  input logic          rst_ni,
  input logic [3:0]    hw_en_i,
  input logic [3:0]    reg_en_i,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [7:0]    wr_data_i,
  input logic [AW-1:0] rd_addr_i,
  input logic [7:0]    rd_data_o,
  input logic [3:0]    clk_p_o,
  input logic [3:0]    clk_n_o
);
  logic [3:0] eff;
  logic [1:0] age_q;

  assign eff = hw_en_i & reg_en_i;

  // falling edges seen since reset release, saturating
  always_ff @(negedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  for (genvar c = 0; c < 4; c++) begin : g_ast
    AST_PARK_LOW: assert property (@(negedge ref_clk_i) disable iff (!rst_ni)
      (!eff[c] && $past(!eff[c])) |=> (!clk_p_o[c] && !clk_n_o[c])); // R4

    AST_RUN_FOLLOWS: assert property (@(negedge ref_clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2 && eff[c] && $past(eff[c])) |=> (clk_p_o[c] && !clk_n_o[c])); // R5

    AST_TRUE_LOW_PHASE: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
      !clk_p_o[c]); // R7
  end

  AST_WR_READBACK: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && rd_addr_i == $past(wr_addr_i)) |-> rd_data_o == $past(wr_data_i)); // R8

  AST_RESET_QUIET: assert property (@(posedge ref_clk_i)
    !rst_ni |-> (clk_p_o == 4'h0 && clk_n_o == 4'h0)); // R6
endmodule

bind ref_clk_fanout ref_clk_fanout_chk #(.AW(ADDR_W)) u_chk (
  .ref_clk_i (ref_clk_i),
  .rst_ni    (rst_ni),
  .hw_en_i   (hw_en_i),
  .reg_en_i  (reg_en),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .clk_p_o   (clk_p_o),
  .clk_n_o   (clk_n_o)
);

// File: tb/ref_clk_fanout_tb_top.sv
`timescale 1ns/1ps
module ref_clk_fanout_tb_top;
  logic       ref_clk = 1'b0;
  logic       rst_ni  = 1'b1;
  logic [3:0] hw_en   = 4'hF;
  logic       wr_en   = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] clk_p, clk_n;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string tag   = "R6";

  ref_clk_fanout dut_i (
    .ref_clk_i (ref_clk),
    .rst_ni    (rst_ni),
    .hw_en_i   (hw_en),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .clk_p_o   (clk_p),
    .clk_n_o   (clk_n)
  );

  always #5 ref_clk = ~ref_clk;

  // ---------------- reference model ----------------
  logic [7:0] rm [4];
  logic [3:0] m_p = '0;
  logic [3:0] m_n = '0;
  logic [3:0] hist [$];
  int by [4] = '{1, 1, 2, 2};
  int bi [4] = '{2, 0, 7, 6};

  function automatic logic [3:0] ctl_bits();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) v[c] = rm[by[c]][bi[c]];
    return v;
  endfunction

  always @(posedge ref_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rm[0] = 8'h00; rm[1] = 8'h05; rm[2] = 8'hC0; rm[3] = 8'h00;
      m_n = '0;
    end else begin
      if (wr_en) rm[wr_addr] = wr_data;
      m_n = m_p;
    end
  end

  always @(negedge ref_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_p = '0;
      hist.delete();
    end else begin
      if (hist.size() > 0) m_p = hist[$];
      hist.push_back(hw_en & ctl_bits());
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  always @(ref_clk) begin
    logic [3:0] ep, en;
    #2;
    if (!done) begin
      ep = ref_clk ? m_p : 4'h0;
      en = ref_clk ? 4'h0 : m_n;
      n_cmp++;
      if (clk_p !== ep || clk_n !== en) begin
        n_bad++;
        $display("FAIL %s/%s t=%0t p=%b n=%b exp p=%b n=%b", tag,
                 ((m_p | m_n) != 0) ? "R5" : "R4", $time, clk_p, clk_n, ep, en);
      end
    end
  end

  // ---------------- pulse width monitor (R7) ----------------
  realtime    lp [4] = '{0.0, 0.0, 0.0, 0.0};
  realtime    ln [4] = '{0.0, 0.0, 0.0, 0.0};
  logic [3:0] pp = '0;
  logic [3:0] pn = '0;

  always @(clk_p or clk_n) begin
    for (int c = 0; c < 4; c++) begin
      if (clk_p[c] !== pp[c]) begin
        if (!rst_ni) lp[c] = 0.0;
        else begin
          if (lp[c] > 0.0 && !done) begin
            n_cmp++;
            if ($realtime - lp[c] < 4.99) begin
              n_bad++;
              $display("FAIL R7 ch%0d p pulse %0.3f ns exp >= 5.0", c, $realtime - lp[c]);
            end
          end
          lp[c] = $realtime;
        end
      end
      if (clk_n[c] !== pn[c]) begin
        if (!rst_ni) ln[c] = 0.0;
        else begin
          if (ln[c] > 0.0 && !done) begin
            n_cmp++;
            if ($realtime - ln[c] < 4.99) begin
              n_bad++;
              $display("FAIL R7 ch%0d n pulse %0.3f ns exp >= 5.0", c, $realtime - ln[c]);
            end
          end
          ln[c] = $realtime;
        end
      end
    end
    pp = clk_p;
    pn = clk_n;
  end

  // ---------------- tasks ----------------
  task automatic cyc(input int n);
    repeat (n) @(posedge ref_clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge ref_clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge ref_clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [7:0] exp, input string t);
    rd_addr = a;
    #1;
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s byte%0d read %h exp %h", t, a, rd_data, exp);
    end
  endtask

  task automatic chk_run(input logic [3:0] er, input string t);
    @(posedge ref_clk); #2;
    n_cmp++;
    if (clk_p !== er || clk_n !== 4'h0) begin
      n_bad++;
      $display("FAIL %s high phase p=%b n=%b exp p=%b n=0000", t, clk_p, clk_n, er);
    end
    @(negedge ref_clk); #2;
    n_cmp++;
    if (clk_p !== 4'h0 || clk_n !== er) begin
      n_bad++;
      $display("FAIL %s low phase p=%b n=%b exp p=0000 n=%b", t, clk_p, clk_n, er);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    #1 rst_ni = 1'b0;
    #20;
    n_cmp++;
    if (clk_p !== 4'h0 || clk_n !== 4'h0) begin
      n_bad++;
      $display("FAIL R6 in reset p=%b n=%b exp 0000/0000", clk_p, clk_n);
    end
    chk_rd(2'd0, 8'h00, "R6");
    chk_rd(2'd1, 8'h05, "R6");
    chk_rd(2'd2, 8'hC0, "R6");
    chk_rd(2'd3, 8'h00, "R6");
    #1 rst_ni = 1'b1;

    tag = "R5";
    cyc(5);
    chk_run(4'hF, "R5");

    tag = "R2";
    wr(2'd1, 8'h01);
    cyc(4); chk_run(4'hE, "R2");
    #3.3 hw_en = 4'b1101;
    cyc(4); chk_run(4'hC, "R2");
    wr(2'd1, 8'h05);
    cyc(4); chk_run(4'hD, "R2");
    #1.7 hw_en = 4'hF;
    cyc(4); chk_run(4'hF, "R2");

    tag = "R3";
    for (int c = 0; c < 4; c++) begin
      logic [7:0] dflt;
      dflt = (by[c] == 1) ? 8'h05 : 8'hC0;
      wr(by[c][1:0], dflt & ~(8'h01 << bi[c]));
      cyc(4);
      chk_run(~(4'h1 << c), "R3");
      chk_rd(by[c][1:0], dflt & ~(8'h01 << bi[c]), "R3");
      wr(by[c][1:0], dflt);
    end
    cyc(4); chk_run(4'hF, "R3");

    tag = "R8";
    wr(2'd0, 8'hA5);
    wr(2'd3, 8'h5A);
    wr(2'd1, 8'hAD);
    wr(2'd2, 8'hC3);
    chk_rd(2'd0, 8'hA5, "R8");
    chk_rd(2'd1, 8'hAD, "R8");
    chk_rd(2'd2, 8'hC3, "R8");
    chk_rd(2'd3, 8'h5A, "R8");
    cyc(4); chk_run(4'hF, "R8");
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h05);
    wr(2'd2, 8'hC0);
    chk_run(4'hF, "R8");

    tag = "R4";
    #6.1 hw_en[2] = 1'b0;
    cyc(3);
    chk_run(4'hB, "R4");
    chk_run(4'hB, "R4");
    #2.9 hw_en[2] = 1'b1;
    cyc(4); chk_run(4'hF, "R4");

    tag = "R7";
    for (int k = 0; k < 20; k++) begin
      @(posedge ref_clk);
      #(0.25 + 0.47 * k);
      hw_en[1] = ~hw_en[1];
      repeat (k % 3) @(posedge ref_clk);
    end
    for (int k = 0; k < 6; k++) begin
      wr(2'd2, (k % 2 == 0) ? 8'h80 : 8'hC0);
      repeat (k % 2) @(posedge ref_clk);
    end
    hw_en = 4'hF;
    cyc(4); chk_run(4'hF, "R7");

    tag = "R1";
    #4.4 hw_en = 4'b1011;
    cyc(4); chk_run(4'b1011, "R1");
    #7.2 hw_en = 4'b0100;
    cyc(4); chk_run(4'b0100, "R1");
    hw_en = 4'hF;
    cyc(4); chk_run(4'hF, "R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge ref_clk);
    done = 1'b1;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired (tag %s) exp completion", tag);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule